// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block gathers fifteen interrupt request lines and presents at most one of them to a CPU as a request with a vector number. The sources are split into six groups. Each group is given one of four priority levels, so every source in a group shares that group's level. A rising edge on a request line latches a pending flag. The flag stays set until software clears it, or until the CPU acknowledges that vector.

The arbiter picks the pending, enabled source with the highest level, using the lowest index to break ties. That source is offered only when it outranks whatever the CPU is already servicing. A four-entry level stack tracks nested service. An acknowledge pushes the offered level onto the stack and a return pops it.

A separate wake output tells the power controller that an enabled, wake-capable source is pending. The wake output ignores the global enable and the current service level, so the device can be brought out of idle or sleep.

Top module: `grp_irq_ctrl`

## Requirements
- R1: A 0-to-1 transition on `src_req_i[s]` sets pending flag s at the next clock edge. The flag stays set after the line falls.
- R2: A high `src_clr_i[s]` clears flag s at the clock edge. A rising request in the same cycle wins and leaves the flag set. An accepted acknowledge clears the flag of the vector it takes.
- R3: Source s belongs to group s mod 6. The level of group g is `grp_prio_i[2g+1:2g]`, where a larger value means higher priority. Among candidates, the highest level is offered.
- R4: Among candidates at the same level, the lowest source index is offered.
- R5: A pending source whose `src_en_i` bit is low keeps its flag but is never offered. Setting the enable later offers it.
- R6: `irq_o` is low whenever `glb_en_i` is low. `vec_o` reads 0 whenever `irq_o` is low.
- R7: While a service level is active, `irq_o` rises only for a candidate whose level is strictly above `act_lvl_o`.
- R8: `ack_i` with `irq_o` high and `ret_i` low makes `act_any_o`=1 and `act_lvl_o` equal to the offered level on the next cycle. `ack_i` with `irq_o` low has no effect.
- R9: `ret_i` pops one nesting level and restores the previous level, or the idle state (`act_any_o`=0). `ret_i` on an empty stack has no effect. When `ret_i` and `ack_i` are high together, only the return is performed.
- R10: `wake_o` is high exactly when some flag is pending with both its `src_en_i` and `wake_mask_i` bits set. This holds regardless of `glb_en_i` and of the active level.
- R11: After reset, all flags are clear, the stack is empty, and `irq_o`, `vec_o`, `act_any_o`, `act_lvl_o` and `wake_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_req_i | input | 15 | Source request lines |
| src_clr_i | input | 15 | Per-source flag clear strobes |
| src_en_i | input | 15 | Per-source enables |
| glb_en_i | input | 1 | Global request enable |
| wake_mask_i | input | 15 | Per-source wake capability |
| grp_prio_i | input | 12 | Two-bit level per group, group g at bits 2g+1:2g |
| ack_i | input | 1 | CPU takes the offered vector |
| ret_i | input | 1 | CPU returns from the current routine |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 4 | Offered source index |
| act_any_o | output | 1 | A service level is active |
| act_lvl_o | output | 2 | Current active level |
| wake_o | output | 1 | Wake request to the power controller |

## Verification
Several properties are checked on every cycle. An offered vector always has its enable set, and the global gate holds. A request during service always outranks the active level. An accepted acknowledge pushes exactly the offered level, while an ignored acknowledge changes nothing. A return always lowers the level or empties the stack, and a wake request always traces back to an enabled, wake-capable source. Other behaviour needs a scenario that sets up state across cycles: flags outliving their request line, set winning over clear, arbitration order between groups and within a group, a source that was disabled being offered once enabled, and the full nest-then-unwind order. The bench's directed scenarios cover these.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;
  localparam int unsigned IRQ_SRC  = 15;
  localparam int unsigned IRQ_GRP  = 6;
  localparam int unsigned IRQ_LVLS = 4;
  localparam int unsigned IRQ_NEST = 4;
endpackage

// File: rtl/irq_flags.sv
module irq_flags #(
  parameter int unsigned N_SRC = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] clr_i,
  input  logic [N_SRC-1:0] ack_clr_i,
  output logic [N_SRC-1:0] flag_o
);
  logic [N_SRC-1:0] req_q, flag_q, rise;

  assign rise = req_i & ~req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      flag_q <= '0;
    end else begin
      req_q  <= req_i;
      // set beats clear
      flag_q <= (flag_q & ~clr_i & ~ack_clr_i) | rise;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_arb.sv
module irq_arb #(
  parameter int unsigned N_SRC = 15,
  parameter int unsigned N_GRP = 6,
  parameter int unsigned LVL_W = 2,
  parameter int unsigned IDX_W = 4
) (
  input  logic [N_SRC-1:0]       cand_i,
  input  logic [N_GRP*LVL_W-1:0] grp_prio_i,
  output logic                   vld_o,
  output logic [IDX_W-1:0]       idx_o,
  output logic [LVL_W-1:0]       lvl_o
);
  logic [LVL_W-1:0] src_lvl [N_SRC];

  for (genvar s = 0; s < N_SRC; s++) begin : g_lvl
    assign src_lvl[s] = grp_prio_i[(s % N_GRP)*LVL_W +: LVL_W];
  end

  // descending scan with >=: highest level, lowest index on ties
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    lvl_o = '0;
    for (int s = N_SRC-1; s >= 0; s--) begin
      if (cand_i[s] && (!vld_o || src_lvl[s] >= lvl_o)) begin
        vld_o = 1'b1;
        idx_o = IDX_W'(s);
        lvl_o = src_lvl[s];
      end
    end
  end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack #(
  parameter int unsigned NEST  = 4,
  parameter int unsigned LVL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic             any_o,
  output logic [LVL_W-1:0] top_o
);
  localparam int unsigned CNT_W = $clog2(NEST+1);

  logic [LVL_W-1:0] stk_q [NEST];
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < NEST; i++) stk_q[i] <= '0;
    end else if (pop_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      for (int i = 0; i < NEST-1; i++) stk_q[i] <= stk_q[i+1];
      stk_q[NEST-1] <= '0;
    end else if (push_i && cnt_q != CNT_W'(NEST)) begin
      cnt_q    <= cnt_q + 1'b1;
      stk_q[0] <= lvl_i;
      for (int i = 1; i < NEST; i++) stk_q[i] <= stk_q[i-1];
    end
  end

  assign any_o = (cnt_q != '0);
  assign top_o = stk_q[0];
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
  import grp_irq_pkg::*;
#(
  parameter int unsigned N_SRC = IRQ_SRC,
  parameter int unsigned N_GRP = IRQ_GRP,
  parameter int unsigned N_LVL = IRQ_LVLS,
  parameter int unsigned NEST  = IRQ_NEST,
  localparam int unsigned IDX_W = $clog2(N_SRC),
  localparam int unsigned LVL_W = $clog2(N_LVL)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_SRC-1:0]       src_req_i,
  input  logic [N_SRC-1:0]       src_clr_i,
  input  logic [N_SRC-1:0]       src_en_i,
  input  logic                   glb_en_i,
  input  logic [N_SRC-1:0]       wake_mask_i,
  input  logic [N_GRP*LVL_W-1:0] grp_prio_i,
  input  logic                   ack_i,
  input  logic                   ret_i,
  output logic                   irq_o,
  output logic [IDX_W-1:0]       vec_o,
  output logic                   act_any_o,
  output logic [LVL_W-1:0]       act_lvl_o,
  output logic                   wake_o
);
  logic [N_SRC-1:0] flag, cand, ack_clr;
  logic             best_vld, take, stk_any;
  logic [IDX_W-1:0] best_idx;
  logic [LVL_W-1:0] best_lvl, stk_top;

  irq_flags #(.N_SRC(N_SRC)) i_flags (
    .clk_i, .rst_ni,
    .req_i     (src_req_i),
    .clr_i     (src_clr_i),
    .ack_clr_i (ack_clr),
    .flag_o    (flag)
  );

  assign cand = flag & src_en_i;

  irq_arb #(.N_SRC(N_SRC), .N_GRP(N_GRP), .LVL_W(LVL_W), .IDX_W(IDX_W)) i_arb (
    .cand_i     (cand),
    .grp_prio_i (grp_prio_i),
    .vld_o      (best_vld),
    .idx_o      (best_idx),
    .lvl_o      (best_lvl)
  );

  assign irq_o   = glb_en_i && best_vld && (!stk_any || best_lvl > stk_top);
  assign vec_o   = irq_o ? best_idx : '0;
  assign take    = ack_i && irq_o && !ret_i;
  assign ack_clr = take ? (N_SRC'(1) << best_idx) : '0;

  irq_lvl_stack #(.NEST(NEST), .LVL_W(LVL_W)) i_stack (
    .clk_i, .rst_ni,
    .push_i (take),
    .pop_i  (ret_i),
    .lvl_i  (best_lvl),
    .any_o  (stk_any),
    .top_o  (stk_top)
  );

  assign act_any_o = stk_any;
  assign act_lvl_o = stk_any ? stk_top : '0;
  assign wake_o    = |(cand & wake_mask_i);
endmodule

// File: rtl/grp_irq_ctrl_chk.sv
module grp_irq_ctrl_chk #(
  parameter int unsigned N_SRC = 15,
  parameter int unsigned N_GRP = 6,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned LVL_W = 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [N_SRC-1:0]       src_en_i,
  input logic                   glb_en_i,
  input logic [N_SRC-1:0]       wake_mask_i,
  input logic [N_GRP*LVL_W-1:0] grp_prio_i,
  input logic                   ack_i,
  input logic                   ret_i,
  input logic                   irq_o,
  input logic [IDX_W-1:0]       vec_o,
  input logic                   act_any_o,
  input logic [LVL_W-1:0]       act_lvl_o,
  input logic                   wake_o
);
  logic [LVL_W-1:0] vec_lvl;
  assign vec_lvl = grp_prio_i[(int'(vec_o) % N_GRP)*LVL_W +: LVL_W];

  AST_IRQ_SRC_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> src_en_i[vec_o]); // R5
  AST_IRQ_GLOBAL_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en_i |-> !irq_o); // R6
  AST_PREEMPT_STRICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && act_any_o |-> vec_lvl > act_lvl_o); // R7
  AST_ACK_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && irq_o && !ret_i |=> act_any_o && act_lvl_o == $past(vec_lvl)); // R8
  AST_ACK_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !irq_o && !ret_i |=> $stable(act_any_o) && $stable(act_lvl_o)); // R8
  AST_RET_LOWERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_i && act_any_o |=> !act_any_o || act_lvl_o < $past(act_lvl_o)); // R9
  AST_RET_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_i && !act_any_o |=> !act_any_o); // R9
  AST_WAKE_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> |(src_en_i & wake_mask_i)); // R10
endmodule

bind grp_irq_ctrl grp_irq_ctrl_chk #(
  .N_SRC(N_SRC), .N_GRP(N_GRP), .IDX_W(IDX_W), .LVL_W(LVL_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .src_en_i(src_en_i), .glb_en_i(glb_en_i),
  .wake_mask_i(wake_mask_i), .grp_prio_i(grp_prio_i), .ack_i(ack_i),
  .ret_i(ret_i), .irq_o(irq_o), .vec_o(vec_o), .act_any_o(act_any_o),
  .act_lvl_o(act_lvl_o), .wake_o(wake_o)
);

// File: tb/test_grp_irq_ctrl.sv
module test_grp_irq_ctrl;
  localparam int NS = 15;
  // g5..g0 = 0,1,2,1,3,0
  localparam logic [11:0] PRIO_DEF = 12'b00_01_10_01_11_00;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [NS-1:0] src_req_i = '0, src_clr_i = '0, src_en_i = '1, wake_mask_i = '0;
  logic glb_en_i = 1'b1, ack_i = 1'b0, ret_i = 1'b0;
  logic [11:0] grp_prio_i = PRIO_DEF;
  logic irq_o, act_any_o, wake_o;
  logic [3:0] vec_o;
  logic [1:0] act_lvl_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  grp_irq_ctrl i_grp_irq_ctrl (.*);

  task automatic tick();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(logic [NS-1:0] m);
    src_req_i = m; tick(); src_req_i = '0;
  endtask

  task automatic clean();
    src_req_i = '0; ack_i = 0; src_clr_i = '1; tick(); src_clr_i = '0;
    ret_i = 1; repeat (4) tick(); ret_i = 0;
    src_en_i = '1; glb_en_i = 1; wake_mask_i = '0; grp_prio_i = PRIO_DEF;
  endtask

  task automatic t_reset();
    chk("R11 irq", irq_o, 0); chk("R11 vec", vec_o, 0);
    chk("R11 any", act_any_o, 0); chk("R11 lvl", act_lvl_o, 0);
    chk("R11 wake", wake_o, 0);
  endtask

  task automatic t_latch_clear();
    src_req_i = 15'd1 << 5; tick();
    chk("R1 irq", irq_o, 1); chk("R1 vec", vec_o, 5);
    src_req_i = '0; tick(); tick();
    chk("R1 held irq", irq_o, 1); chk("R1 held vec", vec_o, 5);
    src_clr_i = 15'd1 << 5; tick(); src_clr_i = '0;
    chk("R2 cleared", irq_o, 0);
    src_req_i = 15'd1 << 5; src_clr_i = 15'd1 << 5; tick();
    src_req_i = '0; src_clr_i = '0;
    chk("R2 set wins", irq_o, 1); chk("R6 vec", vec_o, 5);
    clean();
  endtask

  task automatic t_enable();
    src_en_i[5] = 0; pulse(15'd1 << 5);
    chk("R5 gated", irq_o, 0); chk("R6 vec0", vec_o, 0);
    src_en_i[5] = 1; tick();
    chk("R5 late irq", irq_o, 1); chk("R5 late vec", vec_o, 5);
    clean();
  endtask

  task automatic t_global_wake();
    glb_en_i = 0; wake_mask_i[5] = 1; pulse(15'd1 << 5);
    chk("R6 gate", irq_o, 0); chk("R10 wake glb off", wake_o, 1);
    glb_en_i = 1; tick(); chk("R6 open", irq_o, 1);
    wake_mask_i[5] = 0; tick(); chk("R10 mask", wake_o, 0);
    wake_mask_i[5] = 1; src_en_i[5] = 0; tick(); chk("R10 en", wake_o, 0);
    clean(); chk("R10 none", wake_o, 0);
  endtask

  task automatic t_prio();
    pulse((15'd1 << 0) | (15'd1 << 13));
    chk("R3 high level", vec_o, 13); clean();
    pulse((15'd1 << 2) | (15'd1 << 8));
    chk("R4 same group", vec_o, 2); clean();
    pulse((15'd1 << 2) | (15'd1 << 4));
    chk("R4 cross group", vec_o, 2);
    grp_prio_i[9:8] = 2'd3; tick();
    chk("R3 group field", vec_o, 4);
    clean();
  endtask

  task automatic t_nest();
    ack_i = 1; tick(); ack_i = 0;
    chk("R8 ack ignored", act_any_o, 0);
    ret_i = 1; tick(); ret_i = 0;
    chk("R9 ret empty", act_any_o, 0);
    pulse(15'd1 << 2);
    chk("R3 vec2", vec_o, 2);
    ack_i = 1; tick(); ack_i = 0;
    chk("R8 any", act_any_o, 1); chk("R8 lvl", act_lvl_o, 1);
    chk("R2 ack clears", irq_o, 0);
    pulse(15'd1 << 8);
    chk("R7 equal blocked", irq_o, 0);
    pulse(15'd1 << 3);
    chk("R7 higher irq", irq_o, 1); chk("R7 higher vec", vec_o, 3);
    ack_i = 1; tick(); ack_i = 0;
    chk("R8 nest lvl", act_lvl_o, 2); chk("R7 lower blocked", irq_o, 0);
    ret_i = 1; tick(); ret_i = 0;
    chk("R9 pop lvl", act_lvl_o, 1); chk("R9 pop any", act_any_o, 1);
    chk("R7 still blocked", irq_o, 0);
    ret_i = 1; tick(); ret_i = 0;
    chk("R9 idle", act_any_o, 0);
    chk("R2 no reoffer", vec_o, 8); chk("R7 idle irq", irq_o, 1);
    ack_i = 1; ret_i = 1; tick(); ack_i = 0; ret_i = 0;
    chk("R9 ret over ack", act_any_o, 0); chk("R9 flag kept", vec_o, 8);
    clean();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_latch_clear();
    t_enable();
    t_global_wake();
    t_prio();
    t_nest();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule